// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Arbiter

This block gathers interrupt requests from devices into a grid of priority levels and request slots. Each request is held in a flop until it is acknowledged. The block compares the stored requests with the processor's current priority. A registered pending flag goes high whenever some stored request sits on a level strictly above that priority.

When the processor strobes acknowledge, the block picks one winner. It takes the highest qualifying level and, inside that level, the lowest-numbered slot. It clears that single request and, one cycle later, presents the winner's interrupt vector. Vectors normally come from a per-slot table loaded through a configuration write port. A slot can instead be flagged as device-supplied, and then the vector is taken from an external input at acknowledge time. The block shows the current winner's index on an output so that the device can drive its vector back in the same cycle.

On every level except the lowest, one fixed slot is reserved for software-raised interrupts. That slot always returns a shared constant vector.

Top module: `prio_vec_arb`

## Requirements
- R1: After synchronous reset, no request is stored, `pending` is 0 and `ack_valid` is 0.
- R2: A 1 on `req_set` bit `lvl*NSLOT + slot` stores a request for that level and slot. The request stays stored until an acknowledge selects it.
- R3: `pending` is 1 exactly when a stored request exists on a level numerically greater than `cur_ipl`. Requests at or below `cur_ipl` are ignored. The flag is updated at the same clock edge that samples a new request, a cleared request or a new `cur_ipl`.
- R4: At acknowledge the winner is on the highest qualifying level, and within that level it is the lowest slot index. `sel_idx` shows the current winner index `lvl*NSLOT + slot`.
- R5: Acknowledge clears only the winning request. If `req_set` raises the same bit in the same cycle, the set wins and the request stays stored.
- R6: If no request qualifies when `ack` is sampled, `ack_vec` is 0.
- R7: `ack_valid` is high for exactly the one cycle after the cycle in which `ack` was sampled high. `ack_vec` is valid while `ack_valid` is high.
- R8: A write with `cfg_we` stores `cfg_vec` and `cfg_dyn` for slot `cfg_idx`. The returned vector always has bits [1:0] forced to 0.
- R9: A slot whose stored `cfg_dyn` is 1 returns `dev_vec` as sampled at the acknowledge edge, with bits [1:0] forced to 0.
- R10: Slot `RSV_SLOT` on levels 1 and above always returns `SW_VEC`, whatever its table entry holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | NLVL*NSLOT | One-cycle set strobes, bit lvl*NSLOT+slot |
| cur_ipl | input | log2(NLVL) | Current processor priority |
| cfg_we | input | 1 | Vector table write enable |
| cfg_idx | input | log2(NLVL*NSLOT) | Table slot being written |
| cfg_vec | input | VEC_W | Vector value to store |
| cfg_dyn | input | 1 | Slot takes its vector from the device |
| sel_idx | output | log2(NLVL*NSLOT) | Index of the current winner |
| dev_vec | input | VEC_W | Device-supplied vector |
| ack | input | 1 | Acknowledge strobe |
| pending | output | 1 | A qualifying request is stored |
| ack_valid | output | 1 | Vector result valid |
| ack_vec | output | VEC_W | Winning vector, 0 when nothing qualified |

## Verification
The hardest case to reach from the ports is an acknowledge that clears a bit while `req_set` raises that same bit in the same edge. The bench drives the strobe and the set together on one negedge. It then checks that the vector is returned and that `pending` and `sel_idx` still show the slot. A second hard case is clearing one request out of two on the same level while the other must survive. The bench raises both bits in one cycle before acknowledging.

// File: rtl/avi_qualify.sv
module avi_qualify #(
  parameter int NLVL  = 8,
  parameter int NSLOT = 32,
  localparam int LVLW = $clog2(NLVL)
) (
  input  logic [NLVL*NSLOT-1:0] req,
  input  logic [LVLW-1:0]       cur_lvl,
  output logic                  any
);
  always_comb begin
    any = 1'b0;
    for (int l = 0; l < NLVL; l++) begin
      if ((l > int'(cur_lvl)) && (|req[l*NSLOT +: NSLOT])) any = 1'b1;
    end
  end
endmodule

// File: rtl/avi_pick.sv
module avi_pick #(
  parameter int NLVL  = 8,
  parameter int NSLOT = 32,
  localparam int LVLW  = $clog2(NLVL),
  localparam int SLOTW = $clog2(NSLOT)
) (
  input  logic [NLVL*NSLOT-1:0] req,
  input  logic [LVLW-1:0]       cur_lvl,
  output logic                  hit,
  output logic [LVLW-1:0]       win_lvl,
  output logic [SLOTW-1:0]      win_slot
);
  logic [NSLOT-1:0] lvl_word;

  // highest qualifying level: ascending scan, last match stays
  always_comb begin
    hit     = 1'b0;
    win_lvl = '0;
    for (int l = 0; l < NLVL; l++) begin
      if ((l > int'(cur_lvl)) && (|req[l*NSLOT +: NSLOT])) begin
        hit     = 1'b1;
        win_lvl = LVLW'(l);
      end
    end
  end

  // lowest set slot inside the chosen level: descending scan
  always_comb begin
    lvl_word = req[win_lvl*NSLOT +: NSLOT];
    win_slot = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (lvl_word[s]) win_slot = SLOTW'(s);
    end
  end
endmodule

// File: rtl/avi_vtab.sv
module avi_vtab #(
  parameter int DEPTH = 256,
  parameter int DW    = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/prio_vec_arb.sv
module prio_vec_arb #(
  parameter int NLVL     = 8,
  parameter int NSLOT    = 32,
  parameter int VEC_W    = 9,
  parameter int RSV_SLOT = 31,
  parameter int SW_VEC   = 160,
  localparam int NREQ  = NLVL * NSLOT,
  localparam int LVLW  = $clog2(NLVL),
  localparam int SLOTW = $clog2(NSLOT),
  localparam int IDXW  = LVLW + SLOTW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREQ-1:0]  req_set,
  input  logic [LVLW-1:0]  cur_ipl,
  input  logic             cfg_we,
  input  logic [IDXW-1:0]  cfg_idx,
  input  logic [VEC_W-1:0] cfg_vec,
  input  logic             cfg_dyn,
  output logic [IDXW-1:0]  sel_idx,
  input  logic [VEC_W-1:0] dev_vec,
  input  logic             ack,
  output logic             pending,
  output logic             ack_valid,
  output logic [VEC_W-1:0] ack_vec
);
  logic [NREQ-1:0]  req_q, req_d, clr_mask;
  logic             hit, any_d;
  logic [LVLW-1:0]  win_lvl;
  logic [SLOTW-1:0] win_slot;
  logic [IDXW-1:0]  win_idx;
  logic             hit_q, rsv_q;
  logic [VEC_W-1:0] dev_q, raw_vec;
  logic [VEC_W:0]   tab_rd;

  avi_pick #(.NLVL(NLVL), .NSLOT(NSLOT)) u_pick (
    .req(req_q), .cur_lvl(cur_ipl), .hit(hit), .win_lvl(win_lvl), .win_slot(win_slot)
  );

  assign win_idx  = {win_lvl, win_slot};
  assign sel_idx  = win_idx;
  assign clr_mask = (ack && hit) ? (NREQ'(1) << win_idx) : '0;
  assign req_d    = (req_q & ~clr_mask) | req_set;

  avi_qualify #(.NLVL(NLVL), .NSLOT(NSLOT)) u_qual (
    .req(req_d), .cur_lvl(cur_ipl), .any(any_d)
  );

  avi_vtab #(.DEPTH(NREQ), .DW(VEC_W + 1)) u_vtab (
    .clk(clk), .we(cfg_we), .waddr(cfg_idx), .wdata({cfg_dyn, cfg_vec}),
    .re(ack), .raddr(win_idx), .rdata(tab_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= '0;
      pending   <= 1'b0;
      ack_valid <= 1'b0;
      hit_q     <= 1'b0;
      rsv_q     <= 1'b0;
      dev_q     <= '0;
    end else begin
      req_q     <= req_d;
      pending   <= any_d;
      ack_valid <= ack;
      if (ack) begin
        hit_q <= hit;
        rsv_q <= (win_slot == SLOTW'(RSV_SLOT)) && (win_lvl != '0);
        dev_q <= dev_vec;
      end
    end
  end

  always_comb begin
    if (!hit_q)            raw_vec = '0;
    else if (rsv_q)        raw_vec = VEC_W'(SW_VEC);
    else if (tab_rd[VEC_W]) raw_vec = dev_q;
    else                   raw_vec = tab_rd[VEC_W-1:0];
  end
  assign ack_vec = raw_vec & ~VEC_W'(3);

  // R1/R3: a raised pending flag needs some stored request
  a_r3_pend_needs_req: assert property (@(posedge clk) disable iff (rst)
    pending |-> (|req_q));
  // R2/R5: a set strobe is always stored on the next edge
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|req_set) |=> ((req_q & $past(req_set)) == $past(req_set)));
  // R5: a granted slot without a concurrent set is cleared
  a_r5_winner_cleared: assert property (@(posedge clk) disable iff (rst)
    (ack && hit && !req_set[win_idx]) |=> !req_q[$past(win_idx)]);
  // R5: an acknowledge removes at most one request
  a_r5_one_clear: assert property (@(posedge clk) disable iff (rst)
    ack |=> ($countones($past(req_q) & ~req_q) <= 1));
  // R7: result strobe follows acknowledge by exactly one cycle
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    ack |=> ack_valid);
  a_r7_valid_only_after_ack: assert property (@(posedge clk) disable iff (rst)
    !ack |=> !ack_valid);
  // R6: empty acknowledge yields a zero vector
  a_r6_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (ack && !hit) |=> (ack_vec == '0));
endmodule

// File: tb/sim_prio_vec_arb.sv
module sim_prio_vec_arb;
  localparam int NLVL = 8, NSLOT = 32, VEC_W = 9, NREQ = NLVL * NSLOT;
  localparam int RSV_SLOT = 31, SW_VEC = 160;

  logic clk = 1'b0, rst = 1'b1;
  logic [NREQ-1:0] req_set = '0;
  logic [2:0] cur_ipl = '0;
  logic cfg_we = 1'b0, cfg_dyn = 1'b0, ack = 1'b0;
  logic [7:0] cfg_idx = '0;
  logic [VEC_W-1:0] cfg_vec = '0, dev_vec = '0;
  logic [7:0] sel_idx;
  logic pending, ack_valid;
  logic [VEC_W-1:0] ack_vec;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic [NREQ-1:0] m_req = '0;
  logic [VEC_W-1:0] m_tab [NREQ];
  bit m_dyn [NREQ];
  logic [VEC_W-1:0] exp_q [$];
  string tag_q [$];

  always #4 clk = ~clk;

  prio_vec_arb u0 (
    .clk(clk), .rst(rst), .req_set(req_set), .cur_ipl(cur_ipl),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vec(cfg_vec), .cfg_dyn(cfg_dyn),
    .sel_idx(sel_idx), .dev_vec(dev_vec), .ack(ack),
    .pending(pending), .ack_valid(ack_valid), .ack_vec(ack_vec)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_pend();
    for (int l = 0; l < NLVL; l++)
      if (l > int'(cur_ipl) && |m_req[l*NSLOT +: NSLOT]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int m_win();
    for (int l = NLVL - 1; l > int'(cur_ipl); l--)
      for (int s = 0; s < NSLOT; s++)
        if (m_req[l*NSLOT + s]) return l*NSLOT + s;
    return -1;
  endfunction

  task automatic cfg_wr(input int idx, input int v, input bit dyn);
    cfg_we = 1'b1; cfg_idx = 8'(idx); cfg_vec = VEC_W'(v); cfg_dyn = dyn;
    m_tab[idx] = VEC_W'(v); m_dyn[idx] = dyn;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic raise(input int a, input int b = -1);
    req_set[a] = 1'b1; m_req[a] = 1'b1;
    if (b >= 0) begin req_set[b] = 1'b1; m_req[b] = 1'b1; end
    @(negedge clk);
    req_set = '0;
    chk(pending == m_pend(), "R2 pending after set", pending, m_pend());
  endtask

  task automatic set_ipl(input int v);
    cur_ipl = 3'(v);
    @(negedge clk);
    chk(pending == m_pend(), "R3 pending after priority change", pending, m_pend());
  endtask

  task automatic do_ack(input string tag, input int also_set = -1);
    int w;
    logic [VEC_W-1:0] e;
    w = m_win();
    if (w < 0) e = '0;
    else if ((w % NSLOT) == RSV_SLOT && (w / NSLOT) != 0) e = VEC_W'(SW_VEC);
    else if (m_dyn[w]) e = dev_vec & ~VEC_W'(3);
    else e = m_tab[w] & ~VEC_W'(3);
    if (w >= 0) m_req[w] = 1'b0;
    if (also_set >= 0) begin req_set[also_set] = 1'b1; m_req[also_set] = 1'b1; end
    exp_q.push_back(e); tag_q.push_back(tag);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0; req_set = '0;
    @(negedge clk);
    chk(ack_valid == 1'b0, "R7 valid lasts one cycle", ack_valid, 0);
    chk(pending == m_pend(), "R5 pending after ack", pending, m_pend());
  endtask

  // monitor: compare each produced vector against the scoreboard
  always @(negedge clk) begin
    if (!rst && ack_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected valid", 1, 0);
      else begin
        logic [VEC_W-1:0] ev;
        string t;
        ev = exp_q.pop_front(); t = tag_q.pop_front();
        chk(ack_vec == ev, t, ack_vec, ev);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pending == 1'b0, "R1 pending after reset", pending, 0);
    chk(ack_valid == 1'b0, "R1 valid after reset", ack_valid, 0);
    do_ack("R6 empty ack after reset");

    cfg_wr(3*32+5, 'h107, 1'b0);
    cfg_wr(3*32+9, 'h110, 1'b0);
    cfg_wr(5*32+2, 'h124, 1'b0);
    cfg_wr(6*32+0, 'h000, 1'b1);
    cfg_wr(4*32+31, 'h1FC, 1'b0);
    cfg_wr(2*32+1, 'h0C8, 1'b0);

    set_ipl(3);
    raise(3*32+5);                       // R3: at-level request ignored
    chk(pending == 1'b0, "R3 at-level ignored", pending, 0);
    set_ipl(2);
    chk(pending == 1'b1, "R3 above-level pending", pending, 1);
    raise(3*32+9);
    raise(5*32+2);
    set_ipl(0);
    chk(sel_idx == 8'(5*32+2), "R4 highest level selected", sel_idx, 5*32+2);
    do_ack("R4 highest level vector");
    chk(sel_idx == 8'(3*32+5), "R4 lowest slot selected", sel_idx, 3*32+5);
    do_ack("R8 masked table vector");
    do_ack("R4 remaining slot vector");
    chk(pending == 1'b0, "R5 all cleared", pending, 0);
    do_ack("R6 nothing qualifies");

    raise(3*32+5, 3*32+9);
    do_ack("R4 two-slot level");
    chk(pending == 1'b1, "R5 sibling survives", pending, 1);
    chk(sel_idx == 8'(3*32+9), "R5 sibling index", sel_idx, 3*32+9);
    do_ack("R5 sibling vector");

    raise(5*32+2);
    set_ipl(5);
    chk(pending == 1'b0, "R3 raise priority masks", pending, 0);
    do_ack("R6 masked request gives zero");
    set_ipl(4);
    chk(pending == 1'b1, "R3 lower priority unmasks", pending, 1);
    do_ack("R3 ack at ipl 4");

    set_ipl(0);
    dev_vec = 'h1F3;
    raise(6*32+0);
    chk(sel_idx == 8'(6*32), "R9 device sees winner index", sel_idx, 6*32);
    do_ack("R9 device vector");

    raise(4*32+31);
    do_ack("R10 reserved slot vector");

    raise(2*32+1);
    do_ack("R5 collision vector", 2*32+1);
    chk(pending == 1'b1, "R5 set beats clear", pending, 1);
    chk(sel_idx == 8'(2*32+1), "R5 collided slot kept", sel_idx, 2*32+1);
    do_ack("R2 re-set request served");
    chk(exp_q.size() == 0, "R7 every ack produced a result", exp_q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule